// File: doc/BRIEF.md
# Panel Register Serial Access Sequencer

This block turns a single register access request for a display driver chip into the framed serial traffic that the chip expects on its three-wire serial link. A request names a 16-bit register index and is either a write, which carries a 16-bit value, or a read, which returns a 16-bit value. Every access is sent as two separate chip-select frames. The first is an index frame and the second is a data frame. Each frame opens with a start byte. The start byte holds a fixed 6-bit device identifier in its upper bits, followed by a register-select flag and a direction flag.

The host side uses a simple request interface. It raises `req_valid` with its fields while `req_ready` is high. It then watches `busy`, and waits for the one-cycle `done` pulse. After a read, the result stays on `rd_data` until the next read finishes. The serial side runs in mode 3 (clock idles high, data launched on the falling edge and sampled on the rising edge) and sends the most significant bit first. Each clock half-period lasts a parameterised number of system clocks.

Top module: `lcd_reg_seq`

## Requirements
- R1: Every start byte is `{DEV_ID[5:0], rs, rw}`, with rs in bit 1 and rw in bit 0. With the default `DEV_ID` of 0x1C, the index start byte is 0x70 and the data start byte is 0x72.
- R2: The first frame of every access is 24 bits long. It is the start byte with rs=0 and rw=0, followed by the 16-bit register index, most significant bit first.
- R3: For a write, the second frame is 24 bits long. It is the start byte with rs=1 and rw=0, followed by the 16-bit value, most significant bit first.
- R4: For a read, the second frame is 32 bits long. It is the start byte with rs=1 and rw=0, followed by 24 zero bits on the output line. Of the 32 bits sampled from the input line, only the last 16 bits are kept, and they appear on `rd_data` when `done` pulses. The start-byte bits and the next 8 returned bits are discarded. `rd_data` changes at no other time.
- R5: The serial clock is high whenever chip select is high. Within a frame, the output line changes only on falling clock edges, and the input line is sampled on rising clock edges. Each half-period is `HALF_DIV` system clocks.
- R6: Chip select goes high between the index frame and the data frame for at least `GAP_CYC` system clock cycles, so the two phases are separate frames.
- R7: A request is accepted only while the block is idle (`req_ready` high). A `req_valid` raised during an access is ignored: it neither changes the frames being sent nor adds frames.
- R8: `busy` is high from the cycle after acceptance until the data frame has ended. `done` is high for exactly one cycle at that point, the first cycle in which `busy` is low again.
- R9: A write access leaves `rd_data` unchanged.
- R10: After reset, chip select and the serial clock are high, `busy` and `done` are low, `req_ready` is high and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_index | input | 16 | Panel register index |
| req_wdata | input | 16 | Value to write |
| req_ready | output | 1 | High while idle; a request is taken only then |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse when an access completes |
| rd_data | output | 16 | Result of the most recent read |
| spi_sck | output | 1 | Serial clock, idle high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_miso | input | 1 | Serial data from the panel |

## Verification
The bench runs a panel model that returns a 32-bit pattern with nonzero bits everywhere. A design that kept the wrong slice of a read return, or captured on the wrong clock edge, therefore shows up as a wrong `rd_data` value rather than an accidental match. Index and value extremes (0x0000, 0xFFFF, alternating bits) expose a swapped bit order or a wrong start byte, for example a read that sets the direction flag. One access is poked with a second request while busy, which catches a sequencer that restarts or sends a third frame. The bench also times the chip-select high gap between frames, so a design that merged both phases into one frame fails.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  parameter int unsigned REG_W   = 16;
  parameter int unsigned START_W = 8;
  parameter int unsigned RET_W   = 24;
  parameter int unsigned SHORT_W = START_W + REG_W;
  parameter int unsigned FRAME_W = START_W + RET_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INDEX,
    ST_GAP,
    ST_DATA
  } seq_state_e;

  // Start byte: identifier on top, register-select then direction flag.
  function automatic logic [START_W-1:0] start_byte(
    input logic [START_W-3:0] id,
    input logic               rs,
    input logic               rw
  );
    return {id, rs, rw};
  endfunction

  // Left-aligned frame image for the shifter.
  function automatic logic [FRAME_W-1:0] short_frame(
    input logic [START_W-1:0] sb,
    input logic [REG_W-1:0]   payload
  );
    return {sb, payload, {(FRAME_W-SHORT_W){1'b0}}};
  endfunction

  function automatic logic [FRAME_W-1:0] read_frame(
    input logic [START_W-1:0] sb
  );
    return {sb, {RET_W{1'b0}}};
  endfunction

endpackage

// File: rtl/lcd_spi_shifter.sv
module lcd_spi_shifter #(
  parameter int unsigned MAXB     = 32,
  parameter int unsigned OUT_W    = 16,
  parameter int unsigned HALF_DIV = 2,
  localparam int unsigned CNT_W   = $clog2(MAXB + 1),
  localparam int unsigned DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAXB-1:0]  frame,
  input  logic [CNT_W-1:0] nbits,
  input  logic             miso,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  output logic             fin,
  output logic [OUT_W-1:0] rx
);

  logic [MAXB-1:0]  sreg;
  logic [CNT_W-1:0] left;
  logic [DIV_W-1:0] div;
  logic             run;
  logic             tick;

  assign tick = (div == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      sck  <= 1'b1;
      mosi <= 1'b0;
      sreg <= '0;
      rx   <= '0;
      left <= '0;
      div  <= '0;
      run  <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!run) begin
        if (start) begin
          run  <= 1'b1;
          cs_n <= 1'b0;
          sreg <= frame;
          left <= nbits;
          div  <= '0;
        end
      end else if (!tick) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        if (sck && (left != '0)) begin
          // leading (falling) edge: launch next bit
          sck  <= 1'b0;
          mosi <= sreg[MAXB-1];
          sreg <= {sreg[MAXB-2:0], 1'b0};
        end else if (!sck) begin
          // trailing (rising) edge: sample return bit
          sck  <= 1'b1;
          rx   <= {rx[OUT_W-2:0], miso};
          left <= left - 1'b1;
        end else begin
          cs_n <= 1'b1;
          run  <= 1'b0;
          fin  <= 1'b1;
          mosi <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter logic [START_W-3:0] DEV_ID  = 6'h1C,
  parameter int unsigned        GAP_CYC = 3,
  localparam int unsigned       CNT_W   = $clog2(FRAME_W + 1),
  localparam int unsigned       GAP_W   = $clog2(GAP_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [REG_W-1:0]   req_index,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic               sh_fin,
  input  logic [REG_W-1:0]   sh_rx,
  output logic               sh_start,
  output logic [FRAME_W-1:0] sh_frame,
  output logic [CNT_W-1:0]   sh_nbits,
  output logic               accept,
  output logic               busy,
  output logic               done,
  output logic [REG_W-1:0]   rd_data
);

  seq_state_e       state;
  logic             lat_write;
  logic [REG_W-1:0] lat_wdata;
  logic [GAP_W-1:0] gap_cnt;
  logic             gap_end;

  assign accept  = (state == ST_IDLE) && req_valid;
  assign gap_end = (state == ST_GAP) && (gap_cnt == GAP_W'(GAP_CYC - 1));
  assign busy    = (state != ST_IDLE);

  always_comb begin
    sh_start = 1'b0;
    sh_frame = '0;
    sh_nbits = '0;
    if (accept) begin
      sh_start = 1'b1;
      sh_frame = short_frame(start_byte(DEV_ID, 1'b0, 1'b0), req_index);
      sh_nbits = CNT_W'(SHORT_W);
    end else if (gap_end) begin
      sh_start = 1'b1;
      if (lat_write) begin
        sh_frame = short_frame(start_byte(DEV_ID, 1'b1, 1'b0), lat_wdata);
        sh_nbits = CNT_W'(SHORT_W);
      end else begin
        sh_frame = read_frame(start_byte(DEV_ID, 1'b1, 1'b0));
        sh_nbits = CNT_W'(FRAME_W);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_write <= 1'b0;
      lat_wdata <= '0;
      gap_cnt   <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          lat_write <= req_write;
          lat_wdata <= req_wdata;
          state     <= ST_INDEX;
        end
        ST_INDEX: if (sh_fin) begin
          gap_cnt <= '0;
          state   <= ST_GAP;
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_end) state <= ST_DATA;
        end
        ST_DATA: if (sh_fin) begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (!lat_write) rd_data <= sh_rx;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_reg_seq.sv
module lcd_reg_seq
  import lcd_seq_pkg::*;
#(
  parameter logic [START_W-3:0] DEV_ID   = 6'h1C,
  parameter int unsigned        HALF_DIV = 2,
  parameter int unsigned        GAP_CYC  = 3,
  localparam int unsigned       CNT_W    = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [REG_W-1:0] req_index,
  input  logic [REG_W-1:0] req_wdata,
  output logic             req_ready,
  output logic             busy,
  output logic             done,
  output logic [REG_W-1:0] rd_data,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  // Named internal events, visible to the bound checker.
  logic               sh_start;
  logic               sh_fin;
  logic               accept;
  logic [FRAME_W-1:0] sh_frame;
  logic [CNT_W-1:0]   sh_nbits;
  logic [REG_W-1:0]   sh_rx;

  assign req_ready = !busy;

  lcd_seq_ctrl #(
    .DEV_ID  (DEV_ID),
    .GAP_CYC (GAP_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_index (req_index),
    .req_wdata (req_wdata),
    .sh_fin    (sh_fin),
    .sh_rx     (sh_rx),
    .sh_start  (sh_start),
    .sh_frame  (sh_frame),
    .sh_nbits  (sh_nbits),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data)
  );

  lcd_spi_shifter #(
    .MAXB     (FRAME_W),
    .OUT_W    (REG_W),
    .HALF_DIV (HALF_DIV)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .frame (sh_frame),
    .nbits (sh_nbits),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .fin   (sh_fin),
    .rx    (sh_rx)
  );

endmodule

// File: rtl/lcd_reg_seq_chk.sv
module lcd_reg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        sh_start,
  input logic        sh_fin
);

  a_r5_sck_high_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sck);

  a_r6_launch_from_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> spi_cs_n);

  a_r6_frame_end_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    sh_fin |-> spi_cs_n);

  a_r7_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r4_result_moves_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));

endmodule

bind lcd_reg_seq lcd_reg_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .sh_start  (sh_start),
  .sh_fin    (sh_fin)
);

// File: tb/tb_lcd_reg_seq.sv
module tb_lcd_reg_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int GAP        = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_index = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, busy, done;
  logic [15:0] rd_data;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int compared = 0;
  int mismatched = 0;

  lcd_reg_seq #(.HALF_DIV(HALF), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .req_ready(req_ready),
    .busy(busy), .done(done), .rd_data(rd_data), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- panel model ----------------
  logic [31:0] cur_bits;
  int          cur_n;
  logic [31:0] fr_bits [4];
  int          fr_n    [4];
  time         fr_fall [4];
  time         fr_rise [4];
  int          fcnt = 0;
  int          sck_bad = 0;
  logic [31:0] resp_val = '0;
  logic [31:0] resp_sh  = '0;

  always @(negedge spi_cs_n) begin
    cur_bits = '0;
    cur_n    = 0;
    resp_sh  = resp_val;
    if (!spi_sck) sck_bad++;
    if (fcnt < 4) fr_fall[fcnt] = $time;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    cur_bits = {cur_bits[30:0], spi_mosi};
    cur_n++;
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    spi_miso = resp_sh[31];
    resp_sh  = {resp_sh[30:0], 1'b0};
  end

  always @(posedge spi_cs_n) if (rst_n) begin
    if (fcnt < 4) begin
      fr_bits[fcnt] = cur_bits;
      fr_n[fcnt]    = cur_n;
      fr_rise[fcnt] = $time;
    end
    fcnt++;
  end

  // ---------------- reference functions ----------------
  function automatic logic [7:0] ref_start(input bit rs);
    return 8'h70 + (rs ? 8'd2 : 8'd0);
  endfunction

  function automatic logic [31:0] ref_index_frame(input logic [15:0] idx);
    return (32'(ref_start(1'b0)) << 16) | 32'(idx);
  endfunction

  function automatic logic [31:0] ref_data_frame(input bit wr, input logic [15:0] v);
    if (wr) return (32'(ref_start(1'b1)) << 16) | 32'(v);
    return 32'(ref_start(1'b1)) << 24;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- one access ----------------
  logic [15:0] model_rd = '0;

  task automatic access(input bit wr, input logic [15:0] idx, input logic [15:0] val,
                        input logic [31:0] resp, input bit poke);
    int dcnt = 0;
    int wait_cyc = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    fcnt     = 0;
    resp_val = resp;
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = val;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      repeat (7) @(negedge clk);
      check("R7 not ready while busy", 32'(req_ready), 32'd0);
      req_valid = 1'b1; req_write = ~wr; req_index = ~idx; req_wdata = ~val;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while ((busy || dcnt == 0) && wait_cyc < 3000) begin
      @(negedge clk);
      wait_cyc++;
      if (done) dcnt++;
    end
    repeat (GAP + 4) @(negedge clk);
    if (!wr) model_rd = resp[15:0];
    check("R8 done pulse count", 32'(dcnt), 32'd1);
    check("R7 frames per access", 32'(fcnt), 32'd2);
    check("R2 index frame length", 32'(fr_n[0]), 32'd24);
    check("R1 R2 index frame content", fr_bits[0], ref_index_frame(idx));
    if (wr) begin
      check("R3 write frame length", 32'(fr_n[1]), 32'd24);
      check("R1 R3 write frame content", fr_bits[1], ref_data_frame(1'b1, val));
      check("R9 rd_data kept on write", 32'(rd_data), 32'(model_rd));
    end else begin
      check("R4 read frame length", 32'(fr_n[1]), 32'd32);
      check("R1 R4 read frame content", fr_bits[1], ref_data_frame(1'b0, val));
      check("R4 read result", 32'(rd_data), 32'(model_rd));
    end
    check("R6 deselect gap", 32'((fr_fall[1] - fr_rise[0]) >= GAP * CLK_PERIOD), 32'd1);
    check("R5 sck high at frame start", 32'(sck_bad), 32'd0);
    check("R8 idle after done", 32'(busy), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog: cycles=150000 expected completion earlier");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 cs high in reset", 32'(spi_cs_n), 32'd1);
    check("R10 sck high in reset", 32'(spi_sck), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy low", 32'(busy), 32'd0);
    check("R10 done low", 32'(done), 32'd0);
    check("R10 ready high", 32'(req_ready), 32'd1);
    check("R10 rd_data zero", 32'(rd_data), 32'd0);

    // directed corners
    access(1'b1, 16'h0000, 16'hFFFF, 32'h0, 1'b0);
    access(1'b1, 16'hFFFF, 16'h8001, 32'h0, 1'b0);
    access(1'b0, 16'hA5A5, 16'h0000, 32'hFFFF_5A3C, 1'b0);
    access(1'b1, 16'h0106, 16'h0003, 32'hFFFF_FFFF, 1'b0);
    access(1'b0, 16'h5555, 16'h0000, 32'hC3A5_0001, 1'b1);
    access(1'b1, 16'h0300, 16'h1234, 32'h0, 1'b1);

    // constrained random mix
    for (int i = 0; i < 24; i++) begin
      access(1'($urandom()), 16'($urandom()), 16'($urandom()), $urandom(),
             ($urandom() % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule